// File: doc/BRIEF.md
# Base and Limit Address Checker

This block sits between the processor's address path and memory. Every access the processor issues is compared with a programmable region. A base register gives the lowest physical address the running program may use. A size register gives the number of bytes in that region. In user mode, an access inside the region is granted. An access outside it is held back from memory and raises a fault pulse to the trap controller. The faulting address and the access direction are latched so that the kernel handler can read them.

The grant and fault decision is combinational, in the same cycle as the access strobe. In kernel mode the comparison is skipped and every access is granted. The base and size registers are written through a small configuration port, and only kernel mode may write them. A configuration write issued in user mode is dropped and raises a separate privilege-violation pulse.

The upper bound is formed one bit wider than the address, so a region that reaches the top of the address space cannot wrap around to low addresses. After reset both registers are zero, so every user access faults until the kernel programs a region.

Top module: `bound_guard`

## Requirements
- R1: After reset, base and size are zero, `fault_addr` is zero and `fault_write` is 0. Any user-mode access faults until the registers are programmed.
- R2: When `kmode` is 1 (kernel), every access with `acc_valid` high gets `acc_grant` high and `fault` low in the same cycle, whatever the address.
- R3: In user mode (`kmode` 0), an access whose address A satisfies base <= A < base + size gets `acc_grant` high and `fault` low in the same cycle.
- R4: In user mode, an access with an address below base gets `fault` high and `acc_grant` low in the same cycle.
- R5: In user mode, an access at address base + size or above faults and is not granted. Address base + size - 1 is still granted.
- R6: The sum base + size is evaluated with one extra bit, so it never wraps. With base 0xFFFFFF00 and size 0x200, address 0xFFFFFFFF is granted and address 0x00000010 faults.
- R7: On a clock edge where `fault` is high, `fault_addr` captures the access address and `fault_write` captures `acc_write` (1 = write). Both hold their values until the next fault.
- R8: A configuration write in kernel mode with `cfg_sel` 0 loads base, and with `cfg_sel` 1 loads size. The new value applies to accesses from the next cycle on.
- R9: A configuration write issued in user mode leaves both registers unchanged and pulses `priv_fault` in the same cycle. A kernel write never raises `priv_fault`.
- R10: With `acc_valid` low, `acc_grant` and `fault` are both low.
- R11: With size zero, every user-mode access faults, including an access at base itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Memory access strobe |
| acc_addr | input | AW | Physical address of the access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| kmode | input | 1 | Current privilege: 1 = kernel, 0 = user |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Target register: 0 = base, 1 = size |
| cfg_data | input | AW | Value to write |
| acc_grant | output | 1 | Access may proceed to memory |
| fault | output | 1 | Protection fault, single-cycle, to the trap controller |
| priv_fault | output | 1 | A register write from user mode was refused |
| fault_addr | output | AW | Address of the most recent faulting access |
| fault_write | output | 1 | Direction of the most recent faulting access |

## Verification
User accesses are tried at several points:
- just below base, at base, at the last byte of the region, at base + size, and far above it. These separate an off-by-one at either edge from a correct half-open range.
- with a region that ends beyond the top of the address space. This tells a widened sum apart from a wrapping one.
- with size zero. This shows that an empty region grants nothing.

The same out-of-range addresses are then issued in kernel mode, which shows that the bypass covers all of them. Configuration writes are issued in user mode and then probed with accesses that would only pass if the write had taken effect. Successive faults with different addresses and directions show that the captured address follows the latest fault and holds between faults.

// File: rtl/bound_guard.sv
module bound_guard #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  input  logic          kmode,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_data,
  output logic          acc_grant,
  output logic          fault,
  output logic          priv_fault,
  output logic [AW-1:0] fault_addr,
  output logic          fault_write
);

  localparam int SW = AW + 1;

  logic [AW-1:0] base_q;
  logic [AW-1:0] size_q;
  logic [SW-1:0] top_w;
  logic          in_region;
  logic          cfg_ok;

  assign top_w     = {1'b0, base_q} + {1'b0, size_q};
  assign in_region = ({1'b0, acc_addr} >= {1'b0, base_q}) &&
                     ({1'b0, acc_addr} <  top_w);

  assign acc_grant  = acc_valid && (kmode || in_region);
  assign fault      = acc_valid && !kmode && !in_region;
  assign priv_fault = cfg_we && !kmode;
  assign cfg_ok     = cfg_we && kmode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else if (cfg_ok) begin
      if (cfg_sel) size_q <= cfg_data;
      else         base_q <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_addr  <= '0;
      fault_write <= 1'b0;
    end else if (fault) begin
      fault_addr  <= acc_addr;
      fault_write <= acc_write;
    end
  end

endmodule

// File: rtl/bound_guard_chk.sv
module bound_guard_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic          acc_write,
  input logic          kmode,
  input logic          cfg_we,
  input logic          acc_grant,
  input logic          fault,
  input logic          priv_fault,
  input logic [AW-1:0] fault_addr,
  input logic          fault_write,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] size_q
);

  AST_KERNEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && kmode) |-> (acc_grant && !fault)); // R2

  AST_GRANT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_grant != fault)); // R3

  AST_BELOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !kmode && (acc_addr < base_q)) |-> fault); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_grant && !fault)); // R10

  AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault_addr == $past(acc_addr) && fault_write == $past(acc_write))); // R7

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |=> ($stable(fault_addr) && $stable(fault_write))); // R7

  AST_USER_CFG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !kmode) |-> priv_fault); // R9

  AST_USER_CFG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !kmode) |=> ($stable(base_q) && $stable(size_q))); // R9

  AST_EMPTY_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == '0 && acc_valid && !kmode) |-> fault); // R11

endmodule

bind bound_guard bound_guard_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_write(acc_write), .kmode(kmode), .cfg_we(cfg_we),
  .acc_grant(acc_grant), .fault(fault), .priv_fault(priv_fault),
  .fault_addr(fault_addr), .fault_write(fault_write),
  .base_q(base_q), .size_q(size_q)
);

// File: tb/sim_bound_guard.sv
`timescale 1ns/1ps
module sim_bound_guard;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_write = 1'b0;
  logic          kmode = 1'b0;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [AW-1:0] cfg_data = '0;
  logic          acc_grant, fault, priv_fault, fault_write;
  logic [AW-1:0] fault_addr;

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] exp_faddr = '0;
  logic          exp_fwr   = 1'b0;

  always #4 clk = ~clk;

  bound_guard #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .kmode(kmode), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .acc_grant(acc_grant), .fault(fault),
    .priv_fault(priv_fault), .fault_addr(fault_addr), .fault_write(fault_write)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input string req, input logic [AW-1:0] a, input logic wr,
                        input logic km, input logic exp_ok);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = wr; kmode = km;
    #1;
    chk(req, {62'd0, acc_grant, fault}, {62'd0, exp_ok, !exp_ok});
    @(negedge clk);
    acc_valid = 1'b0; kmode = 1'b0;
    if (!exp_ok) begin exp_faddr = a; exp_fwr = wr; end
    chk(req, {31'd0, fault_write, fault_addr}, {31'd0, exp_fwr, exp_faddr});
  endtask

  task automatic cfg(input string req, input logic sel, input logic [AW-1:0] d,
                     input logic km);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d; kmode = km;
    #1;
    chk(req, {63'd0, priv_fault}, {63'd0, !km});
    @(negedge clk);
    cfg_we = 1'b0; kmode = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1", {31'd0, fault_write, fault_addr}, 64'd0);
    access("R1", 32'h0, 1'b0, 1'b0, 1'b0);
    access("R11", 32'h0000_0100, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    acc_addr = 32'h5; kmode = 1'b0;
    #1;
    chk("R10", {62'd0, acc_grant, fault}, 64'd0);
  endtask

  task automatic t_region;
    cfg("R8", 1'b0, 32'h0000_1000, 1'b1);
    cfg("R8", 1'b1, 32'h0000_0100, 1'b1);
    access("R3", 32'h0000_1000, 1'b0, 1'b0, 1'b1);
    access("R3", 32'h0000_1080, 1'b1, 1'b0, 1'b1);
    access("R5", 32'h0000_10FF, 1'b0, 1'b0, 1'b1);
    access("R5", 32'h0000_1100, 1'b1, 1'b0, 1'b0);
    access("R4", 32'h0000_0FFF, 1'b0, 1'b0, 1'b0);
    access("R5", 32'h8000_0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_kernel;
    access("R2", 32'h0000_0FFF, 1'b1, 1'b1, 1'b1);
    access("R2", 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_user_cfg;
    cfg("R9", 1'b0, 32'h0000_0000, 1'b0);
    cfg("R9", 1'b1, 32'hFFFF_0000, 1'b0);
    access("R9", 32'h0000_0800, 1'b0, 1'b0, 1'b0);
    access("R9", 32'h0000_1100, 1'b1, 1'b0, 1'b0);
    access("R9", 32'h0000_1010, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_wrap;
    cfg("R8", 1'b0, 32'hFFFF_FF00, 1'b1);
    cfg("R8", 1'b1, 32'h0000_0200, 1'b1);
    access("R6", 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1);
    access("R6", 32'h0000_0010, 1'b0, 1'b0, 1'b0);
    access("R6", 32'hFFFF_FF00, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_empty;
    cfg("R8", 1'b0, 32'h0000_2000, 1'b1);
    cfg("R8", 1'b1, 32'h0000_0000, 1'b1);
    access("R11", 32'h0000_2000, 1'b1, 1'b0, 1'b0);
    access("R11", 32'h0000_2001, 1'b0, 1'b0, 1'b0);
    access("R2", 32'h0000_2000, 1'b0, 1'b1, 1'b1);
    access("R7", 32'h0000_2000, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_region();
    t_kernel();
    t_user_cfg();
    t_wrap();
    t_empty();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule